// File: doc/BRIEF.md
# Segment LCD Column Driver Core

This block is the digital core of an 80-column segment driver for a multiplexed liquid-crystal panel. A row of display bits is collected into a data latch. A mode pin picks the loading path: in parallel mode four bits enter per data-clock cycle, and in serial mode one bit enters per cycle. A falling edge of the latch pulse copies the collected row into a line latch. A 2-bit level code is then formed for every segment from the line latch, the frame-inversion input and a display-enable input. The codes name the drive rails VSS, V0, V2 and V3. Analog level shifting and the real voltages lie outside the block.

The data clock `xck` and the latch pulse `lp` are sampled by the system clock `clk`, and their falling edges are detected in that domain. A small display state machine has three states:
- `ST_SHOW`: the line latch is shown through the truth table.
- `ST_OFF`: `blank_n` is low, so every segment is forced to VSS and the line latch is held clear.
- `ST_BLANK`: display-off has been released. The non-select level is shown until the next latch pulse.

The machine has four transitions:
- `ST_SHOW` goes to `ST_OFF` when `blank_n` is low.
- `ST_OFF` goes to `ST_BLANK` when `blank_n` is high.
- `ST_BLANK` goes to `ST_OFF` when `blank_n` is low.
- `ST_BLANK` goes to `ST_SHOW` on a falling `lp` edge while `blank_n` is high.

Top module: `seg_col_driver`

## Requirements
- R1: After reset the data latch, line latch and fill pointer are cleared and the state is `ST_SHOW`. Every segment therefore shows the clear-bit code: 2'b10 when `frm_inv` is high and 2'b11 when it is low.
- R2: Serial mode is selected by `par_mode`=0. Each detected falling edge of `xck` stores `din[0]` at segment position `ptr` and advances `ptr` by 1. `din[3:1]` have no effect. The first bit after a latch pulse lands on SEG0.
- R3: Parallel mode is selected by `par_mode`=1. Each detected falling edge of `xck` stores `din[j]` at position `ptr+j` for j = 0..3 and advances `ptr` by 4.
- R4: Every falling edge of `lp` returns the pointer to 0. Positions that are not rewritten keep their earlier data-latch value.
- R5: Data bits aimed at positions beyond SEG79 are dropped. The pointer stops at 80 and never wraps.
- R6: A falling edge of `lp` copies the data latch into the line latch. The outputs change one `clk` edge after the sampled `lp` fall, and `xck` activity alone never changes them.
- R7: Segment i is coded from line bit i as follows. When `frm_inv` is 1, a set bit gives 2'b01 (V0) and a clear bit gives 2'b10 (V2). When `frm_inv` is 0, a set bit gives 2'b00 (VSS) and a clear bit gives 2'b11 (V3).
- R8: While `blank_n` is low, every output is 2'b00 from the next `clk` edge on and the line latch is held clear. Data keeps loading into the data latch, and a latch pulse in this state leaves the line latch clear.
- R9: After `blank_n` rises, every output shows the non-select code (2'b10 when `frm_inv`=1, 2'b11 when `frm_inv`=0). The data-latch contents appear only at the next falling `lp` edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all inputs |
| rst_n | input | 1 | Active-low asynchronous reset |
| xck | input | 1 | Data clock; display data is taken on its falling edge |
| lp | input | 1 | Latch pulse; its falling edge moves the row into the line latch |
| par_mode | input | 1 | 1 = four bits per data clock, 0 = one bit on din[0] |
| din | input | 4 | Display data bits |
| blank_n | input | 1 | Low forces all segments to VSS and clears the line latch |
| frm_inv | input | 1 | Frame-inversion input used by the level truth table |
| seg_lvl | output | 160 | Level code per segment, SEG i at bits [2i+1:2i] |

## Verification
A wrong pointer shows up at the ports on the next latch pulse. Bits land on shifted segments, SEG0 is overwritten after an overflow, or old columns fail to survive a partial load. A wrong line-latch or state value shows up one `clk` edge after the stimulus that exposes it: non-VSS codes while display-off is low, data appearing during the non-select window, or a latch pulse that has no effect. Because the truth table is combinational in `frm_inv`, each captured row is checked under both inversion values, so a swapped code pair is exposed at once.

// File: rtl/seg_drv_pkg.sv
package seg_drv_pkg;
    typedef enum logic [1:0] {
        LVL_VSS = 2'b00,
        LVL_V0  = 2'b01,
        LVL_V2  = 2'b10,
        LVL_V3  = 2'b11
    } lvl_t;

    typedef enum logic [1:0] {
        ST_SHOW  = 2'b00,
        ST_OFF   = 2'b01,
        ST_BLANK = 2'b10
    } disp_st_t;
endpackage

// File: rtl/seg_data_load.sv
module seg_data_load #(
    parameter int unsigned NSEG = 80,
    parameter int unsigned PW   = 4,
    localparam int unsigned PTRW = $clog2(NSEG + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            shift_stb,
    input  logic            restart,
    input  logic            par_mode,
    input  logic [PW-1:0]   din,
    output logic [NSEG-1:0] data_q,
    output logic [PTRW-1:0] ptr_q
);
    logic [NSEG-1:0] data_d;
    logic [PTRW:0]   sum;
    logic [PTRW-1:0] ptr_d;

    // Each position compares itself with ptr+j; positions past NSEG-1 do not exist,
    // so overflowing bits fall away without extra logic.
    always_comb begin
        data_d = data_q;
        for (int i = 0; i < int'(NSEG); i++) begin
            for (int j = 0; j < int'(PW); j++) begin
                if ((par_mode || j == 0) && (PTRW'(i) == ptr_q + PTRW'(j)))
                    data_d[i] = din[j];
            end
        end
        sum = {1'b0, ptr_q} + (par_mode ? (PTRW+1)'(PW) : (PTRW+1)'(1));
        if (ptr_q >= PTRW'(NSEG))
            ptr_d = ptr_q;
        else if (sum > (PTRW+1)'(NSEG))
            ptr_d = PTRW'(NSEG);
        else
            ptr_d = sum[PTRW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            ptr_q  <= '0;
        end else if (restart) begin
            ptr_q  <= '0;
        end else if (shift_stb) begin
            data_q <= data_d;
            ptr_q  <= ptr_d;
        end
    end
endmodule

// File: rtl/seg_line_latch.sv
module seg_line_latch #(
    parameter int unsigned NSEG = 80
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            load,
    input  logic [NSEG-1:0] d,
    output logic [NSEG-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (clr)
            q <= '0;
        else if (load)
            q <= d;
    end
endmodule

// File: rtl/seg_level_map.sv
module seg_level_map
    import seg_drv_pkg::*;
#(
    parameter int unsigned NSEG = 80
) (
    input  logic [NSEG-1:0]   line,
    input  logic              frm_inv,
    input  logic              force_vss,
    input  logic              force_nsel,
    output logic [2*NSEG-1:0] seg_lvl
);
    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        lvl_t lv;
        always_comb begin
            if (force_vss)
                lv = LVL_VSS;
            else if (force_nsel || !line[g])
                lv = frm_inv ? LVL_V2 : LVL_V3;
            else
                lv = frm_inv ? LVL_V0 : LVL_VSS;
        end
        assign seg_lvl[2*g +: 2] = lv;
    end
endmodule

// File: rtl/seg_col_driver.sv
module seg_col_driver
    import seg_drv_pkg::*;
#(
    parameter int unsigned NSEG = 80,
    parameter int unsigned PW   = 4,
    localparam int unsigned PTRW = $clog2(NSEG + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xck,
    input  logic              lp,
    input  logic              par_mode,
    input  logic [PW-1:0]     din,
    input  logic              blank_n,
    input  logic              frm_inv,
    output logic [2*NSEG-1:0] seg_lvl
);
    logic            xck_q, lp_q;
    logic            xck_fall, lp_fall;
    logic [NSEG-1:0] data_q, line_q;
    logic [PTRW-1:0] ptr_q;
    disp_st_t        st_q, st_d;
    logic            force_vss, force_nsel, line_clr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xck_q <= 1'b0;
            lp_q  <= 1'b0;
        end else begin
            xck_q <= xck;
            lp_q  <= lp;
        end
    end

    assign xck_fall = xck_q & ~xck;
    assign lp_fall  = lp_q & ~lp;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= ST_SHOW;
        else
            st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_SHOW:  if (!blank_n) st_d = ST_OFF;
            ST_OFF:   if (blank_n)  st_d = ST_BLANK;
            ST_BLANK: if (!blank_n) st_d = ST_OFF;
                      else if (lp_fall) st_d = ST_SHOW;
            default:  st_d = ST_SHOW;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        force_vss  = 1'b0;
        force_nsel = 1'b0;
        unique case (st_q)
            ST_SHOW:  ;
            ST_OFF:   force_vss  = 1'b1;
            ST_BLANK: force_nsel = 1'b1;
            default:  force_vss  = 1'b1;
        endcase
    end

    assign line_clr = ~blank_n;

    seg_data_load #(.NSEG(NSEG), .PW(PW)) u_load (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_stb (xck_fall),
        .restart   (lp_fall),
        .par_mode  (par_mode),
        .din       (din),
        .data_q    (data_q),
        .ptr_q     (ptr_q)
    );

    seg_line_latch #(.NSEG(NSEG)) u_line (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (line_clr),
        .load  (lp_fall),
        .d     (data_q),
        .q     (line_q)
    );

    seg_level_map #(.NSEG(NSEG)) u_map (
        .line       (line_q),
        .frm_inv    (frm_inv),
        .force_vss  (force_vss),
        .force_nsel (force_nsel),
        .seg_lvl    (seg_lvl)
    );
endmodule

// File: rtl/seg_col_driver_chk.sv
module seg_col_driver_chk
    import seg_drv_pkg::*;
#(
    parameter int unsigned NSEG = 80,
    localparam int unsigned PTRW = $clog2(NSEG + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              blank_n,
    input logic              par_mode,
    input logic              xck_fall,
    input logic              lp_fall,
    input logic [PTRW-1:0]   ptr_q,
    input logic [NSEG-1:0]   line_q,
    input logic [2*NSEG-1:0] seg_lvl,
    input disp_st_t          st_q
);
    a_r5_ptr_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q <= PTRW'(NSEG));

    a_r4_ptr_restart: assert property (@(posedge clk) disable iff (!rst_n)
        lp_fall |=> ptr_q == '0);

    a_r2_serial_step: assert property (@(posedge clk) disable iff (!rst_n)
        (xck_fall && !lp_fall && !par_mode && ptr_q < PTRW'(NSEG))
        |=> ptr_q == $past(ptr_q) + PTRW'(1));

    a_r8_off_vss: assert property (@(posedge clk) disable iff (!rst_n)
        !blank_n |=> seg_lvl == '0);

    a_r8_line_clr: assert property (@(posedge clk) disable iff (!rst_n)
        !blank_n |=> line_q == '0);

    a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_OFF && blank_n) |=> st_q == ST_BLANK);

    a_r9_hold_dark: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_BLANK && blank_n && !lp_fall) |=> st_q == ST_BLANK && line_q == '0);
endmodule

bind seg_col_driver seg_col_driver_chk #(.NSEG(NSEG)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .blank_n  (blank_n),
    .par_mode (par_mode),
    .xck_fall (xck_fall),
    .lp_fall  (lp_fall),
    .ptr_q    (ptr_q),
    .line_q   (line_q),
    .seg_lvl  (seg_lvl),
    .st_q     (st_q)
);

// File: tb/seg_col_driver_tb.sv
`timescale 1ns/1ps
module seg_col_driver_tb;
    localparam int NSEG = 80;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              xck = 1'b0, lp = 1'b0, par_mode = 1'b0;
    logic [3:0]        din = '0;
    logic              blank_n = 1'b1, frm_inv = 1'b0;
    logic [2*NSEG-1:0] seg_lvl;

    int checks = 0, failures = 0;
    bit done = 0;

    // bench model
    logic [NSEG-1:0] m_data = '0, m_line = '0;
    int              m_ptr = 0;
    int              m_st = 0; // 0 show, 1 off, 2 dark

    always #5 clk = ~clk;

    seg_col_driver u_dut (
        .clk(clk), .rst_n(rst_n), .xck(xck), .lp(lp), .par_mode(par_mode),
        .din(din), .blank_n(blank_n), .frm_inv(frm_inv), .seg_lvl(seg_lvl)
    );

    function automatic logic [2*NSEG-1:0] exp_vec(logic [NSEG-1:0] ln, logic fi, int st);
        logic [2*NSEG-1:0] v;
        for (int i = 0; i < NSEG; i++) begin
            if (st == 1)                 v[2*i +: 2] = 2'b00;
            else if (st == 2 || !ln[i])  v[2*i +: 2] = fi ? 2'b10 : 2'b11;
            else                         v[2*i +: 2] = fi ? 2'b01 : 2'b00;
        end
        return v;
    endfunction

    task automatic check_out(string tag);
        logic [2*NSEG-1:0] e;
        e = exp_vec(m_line, frm_inv, m_st);
        checks++;
        if (seg_lvl !== e) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", tag, seg_lvl, e);
        end
    endtask

    task automatic check_both(string tag);
        frm_inv = 1'b1; #1; check_out(tag);
        frm_inv = 1'b0; #1; check_out(tag);
    endtask

    task automatic clk_word(logic [3:0] d);
        din = d; xck = 1'b1;
        @(negedge clk); xck = 1'b0;
        @(negedge clk);
        if (m_ptr < NSEG) begin
            if (par_mode) begin
                for (int j = 0; j < 4; j++)
                    if (m_ptr + j < NSEG) m_data[m_ptr + j] = d[j];
                m_ptr = (m_ptr + 4 > NSEG) ? NSEG : m_ptr + 4;
            end else begin
                m_data[m_ptr] = d[0];
                m_ptr = m_ptr + 1;
            end
        end
    endtask

    task automatic load_bits(logic [NSEG-1:0] row, bit par, int nbits);
        par_mode = par;
        if (par) begin
            for (int k = 0; k < nbits; k += 4) clk_word(row[k +: 4]);
        end else begin
            for (int k = 0; k < nbits; k++) begin
                logic [2:0] junk;
                junk = 3'($urandom());
                clk_word({junk, row[k]});
            end
        end
    endtask

    task automatic pulse_lp();
        lp = 1'b1;
        @(negedge clk); lp = 1'b0;
        @(negedge clk);
        m_ptr = 0;
        if (blank_n) begin
            m_line = m_data;
            if (m_st == 2) m_st = 0;
        end
    endtask

    task automatic set_blank(logic v);
        blank_n = v;
        @(negedge clk);
        if (!v) begin m_st = 1; m_line = '0; end
        else if (m_st == 1) m_st = 2;
    endtask

    function automatic logic [NSEG-1:0] rnd_row();
        logic [95:0] t;
        t = {$urandom(), $urandom(), $urandom()};
        return t[NSEG-1:0];
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [NSEG-1:0] r;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_both("R1 reset state");

        // random rows in both modes
        for (int n = 0; n < 8; n++) begin
            bit par;
            par = n[0];
            r = rnd_row();
            load_bits(r, par, NSEG);
            check_out("R6 no change before latch");
            pulse_lp();
            check_both(par ? "R3 parallel row R7" : "R2 serial row R7");
        end

        // overflow: 80 serial bits then 4 extra inverted
        r = rnd_row();
        load_bits(r, 1'b0, NSEG);
        load_bits(~r, 1'b0, 4);
        pulse_lp();
        check_both("R5 serial overflow dropped");
        r = rnd_row();
        load_bits(r, 1'b1, NSEG);
        load_bits(~r, 1'b1, 8);
        pulse_lp();
        check_both("R5 parallel overflow dropped");

        // partial reload keeps the tail
        load_bits(~r, 1'b0, 8);
        pulse_lp();
        check_both("R4 partial reload");
        load_bits(r, 1'b1, 12);
        pulse_lp();
        check_both("R4 restart at SEG0");

        // display-off
        set_blank(1'b0);
        check_both("R8 off forces VSS");
        r = rnd_row();
        load_bits(r, 1'b1, NSEG);
        check_both("R8 loading while off");
        pulse_lp();
        check_both("R8 latch while off");
        load_bits(~r, 1'b1, NSEG);
        set_blank(1'b1);
        check_both("R9 non-select after release");
        pulse_lp();
        check_both("R9 data after latch");

        // off/on again, new data appears only at latch
        set_blank(1'b0);
        set_blank(1'b1);
        r = rnd_row();
        load_bits(r, 1'b0, NSEG);
        check_both("R9 still dark during load");
        pulse_lp();
        check_both("R9 serial data after latch");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule